// File: doc/BRIEF.md
# Manchester Transmit Encoder with Loopback

This block is the digital transmit half of a 10 Mb/s twisted-pair Ethernet port. Its only timing reference is a 20 MHz clock. From that clock it produces a 10 MHz transmit clock for the MAC. On each rising edge of that clock it samples one serial data bit while the MAC holds transmit enable high. Each bit goes out as two 50 ns half-cells in Manchester code. When the MAC drops transmit enable, the encoder drives a fixed-width high start-of-idle pulse and then releases the line to idle.

The MAC interface is paced by the transmit clock the block generates. There is no ready or back-pressure: the encoder accepts one bit per transmit-clock period for as long as transmit enable stays high. A local loopback input diverts the encoded stream to a receive-side port and keeps the line output quiet. A full-duplex input has priority over loopback and also masks the collision report toward the MAC.

Top module: `mtx_encoder`

## Requirements
- R1: `tx_clk` is high while reset is held. After reset it changes level on every reference clock edge, so its period is two reference cycles.
- R2: Bits are sampled only at the reference edge where `tx_clk` rises. If `tx_en` is low at that edge while the line is idle, `line_out` stays 0 and `line_oe` stays 0.
- R3: A sampled bit of 1 is sent as a low half-cell followed by a high half-cell. A sampled bit of 0 is sent as high then low. The first half-cell appears in the reference cycle that follows the sampling edge, and each half-cell lasts one reference cycle.
- R4: When `tx_en` is sampled low after a frame, the output is held at 1 with output enable high for SOI_CYCLES reference cycles (default 6, i.e. 300 ns). After that, `line_out` and `line_oe` both return to 0.
- R5: `tx_active` is 1 from the first half-cell of a frame until the last cycle of its start-of-idle pulse. It is 0 at all other times.
- R6: While `loopback` is 1 and `full_duplex` is 0, `line_out` and `line_oe` are 0. In this state the encoded stream, including the start-of-idle pulse, appears on `lb_data`, and `lb_valid` takes the value the output enable would have had.
- R7: While `full_duplex` is 1, `loopback` is ignored: the stream goes to the line, `lb_valid` is 0, and `col_out` is 0.
- R8: While `full_duplex` is 0, `col_out` follows `coll_in`.
- R9: During and just after reset, `line_out`, `line_oe`, `tx_active`, `lb_valid` and `lb_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_data | input | 1 | Serial transmit data from the MAC |
| loopback | input | 1 | Local loopback request |
| full_duplex | input | 1 | Full-duplex mode; overrides loopback and masks collisions |
| coll_in | input | 1 | Collision indication from the line side |
| tx_clk | output | 1 | 10 MHz transmit clock to the MAC |
| line_out | output | 1 | Manchester-coded line data |
| line_oe | output | 1 | Line driver enable |
| lb_data | output | 1 | Encoded stream returned toward the receive path |
| lb_valid | output | 1 | Looped-back stream is present |
| col_out | output | 1 | Collision report to the MAC |
| tx_active | output | 1 | Transmission in progress, for status indicators |

## Verification
Two functions can act in the same cycle: the loopback diversion and the full-duplex override. They are provoked by holding `loopback` and `full_duplex` high together for a whole frame. The result passes only if every half-cell, and the start-of-idle pulse, reach `line_out` unchanged while `lb_valid` stays low. Collision masking is exercised in the same mode. A separate frame with loopback alone must leave the line silent for every cycle, while the decoded half-cells on `lb_data` still match the driven bits.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_SOI  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/mtx_clkgen.sv
module mtx_clkgen (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic tx_clk
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign phase  = ph_q;
  assign tx_clk = ~ph_q;

  // R1: the MAC clock alternates on every reference edge
  a_r1_clk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q |=> !ph_q);
endmodule

// File: rtl/mtx_core.sv
module mtx_core
  import mtx_pkg::*;
#(
  parameter int SOI_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic tx_en,
  input  logic tx_data,
  output logic enc,
  output logic enc_oe,
  output logic active
);
  localparam int CNT_W = (SOI_CYCLES > 1) ? $clog2(SOI_CYCLES) : 1;

  tx_state_e  st;
  logic       bit_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      enc    <= 1'b0;
      enc_oe <= 1'b0;
      active <= 1'b0;
      bit_q  <= 1'b0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (phase && tx_en) begin
            st     <= S_DATA;
            bit_q  <= tx_data;
            enc    <= ~tx_data;
            enc_oe <= 1'b1;
            active <= 1'b1;
          end
        end
        S_DATA: begin
          if (!phase) begin
            enc <= bit_q;
          end else if (tx_en) begin
            bit_q <= tx_data;
            enc   <= ~tx_data;
          end else begin
            st  <= S_SOI;
            enc <= 1'b1;
            cnt <= CNT_W'(SOI_CYCLES - 1);
          end
        end
        S_SOI: begin
          if (cnt == '0) begin
            st     <= S_IDLE;
            enc    <= 1'b0;
            enc_oe <= 1'b0;
            active <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: every bit cell carries a mid-cell transition
  a_r3_midbit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !phase) |=> (enc != $past(enc)));

  // R4: the start-of-idle interval drives a high, enabled line
  a_r4_soi_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOI) |-> (enc && enc_oe));

  // R2: a frame begins only on the rising edge of the MAC clock
  a_r2_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !phase);

  // R5: the activity flag covers every enabled cycle
  a_r5_active_covers: assert property (@(posedge clk) disable iff (!rst_n)
    enc_oe |-> active);

  // R4: idle line is low and released
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!enc && !enc_oe));
endmodule

// File: rtl/mtx_route.sv
module mtx_route (
  input  logic enc,
  input  logic enc_oe,
  input  logic loopback,
  input  logic full_duplex,
  input  logic coll_in,
  output logic line_out,
  output logic line_oe,
  output logic lb_data,
  output logic lb_valid,
  output logic col_out
);
  logic divert;

  always_comb begin
    divert   = loopback & ~full_duplex;
    line_out = enc    & ~divert;
    line_oe  = enc_oe & ~divert;
    lb_data  = enc    &  divert;
    lb_valid = enc_oe &  divert;
    col_out  = coll_in & ~full_duplex;
  end

  // R6/R7: the stream never leaves on both paths together
  always_comb begin
    a_r6_one_path: assert (!(line_oe && lb_valid));
  end
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder #(
  parameter int SOI_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_data,
  input  logic loopback,
  input  logic full_duplex,
  input  logic coll_in,
  output logic tx_clk,
  output logic line_out,
  output logic line_oe,
  output logic lb_data,
  output logic lb_valid,
  output logic col_out,
  output logic tx_active
);
  logic phase;
  logic enc;
  logic enc_oe;

  mtx_clkgen u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .tx_clk (tx_clk)
  );

  mtx_core #(.SOI_CYCLES(SOI_CYCLES)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .tx_en   (tx_en),
    .tx_data (tx_data),
    .enc     (enc),
    .enc_oe  (enc_oe),
    .active  (tx_active)
  );

  mtx_route u_route (
    .enc         (enc),
    .enc_oe      (enc_oe),
    .loopback    (loopback),
    .full_duplex (full_duplex),
    .coll_in     (coll_in),
    .line_out    (line_out),
    .line_oe     (line_oe),
    .lb_data     (lb_data),
    .lb_valid    (lb_valid),
    .col_out     (col_out)
  );

  // R9: nothing is driven out of reset until a frame starts
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!line_oe && !tx_active && !lb_valid));
endmodule

// File: tb/mtx_encoder_test.sv
module mtx_encoder_test;
  localparam int SOI = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, tx_data = 1'b0, loopback = 1'b0, full_duplex = 1'b0, coll_in = 1'b0;
  logic tx_clk, line_out, line_oe, lb_data, lb_valid, col_out, tx_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mtx_encoder #(.SOI_CYCLES(SOI)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
    .loopback(loopback), .full_duplex(full_duplex), .coll_in(coll_in),
    .tx_clk(tx_clk), .line_out(line_out), .line_oe(line_oe),
    .lb_data(lb_data), .lb_valid(lb_valid), .col_out(col_out),
    .tx_active(tx_active)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Compare the visible stream against an expected value and enable
  task automatic observe(input string req, input logic v, input logic oe);
    if (loopback && !full_duplex) begin
      chk(req, lb_data, v);
      chk(req, lb_valid, oe);
      chk("R6", line_out, 1'b0);
      chk("R6", line_oe, 1'b0);
    end else begin
      chk(req, line_out, v);
      chk(req, line_oe, oe);
      chk("R7", lb_valid, 1'b0);
    end
  endtask

  // Wait for a falling edge of the reference clock just before tx_clk rises
  task automatic sync_low();
    do @(negedge clk); while (tx_clk !== 1'b0);
  endtask

  task automatic t_reset();
    chk("R9", line_out, 1'b0);
    chk("R9", line_oe, 1'b0);
    chk("R9", tx_active, 1'b0);
    chk("R9", lb_valid, 1'b0);
    chk("R1", tx_clk, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", tx_clk, 1'b0);
    @(negedge clk);
    chk("R1", tx_clk, 1'b1);
    @(negedge clk);
    chk("R1", tx_clk, 1'b0);
  endtask

  task automatic t_idle_no_enable();
    tx_en = 1'b0;
    tx_data = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2", line_oe, 1'b0);
      chk("R2", line_out, 1'b0);
      chk("R5", tx_active, 1'b0);
    end
  endtask

  task automatic t_frame(input logic [15:0] pat, input int n, input logic lb, input logic fd);
    loopback = lb;
    full_duplex = fd;
    sync_low();
    chk("R5", tx_active, 1'b0);
    for (int i = 0; i < n; i++) begin
      tx_en = 1'b1;
      tx_data = pat[i];
      @(negedge clk);
      observe("R3", ~pat[i], 1'b1);
      chk("R5", tx_active, 1'b1);
      @(negedge clk);
      observe("R3", pat[i], 1'b1);
    end
    tx_en = 1'b0;
    tx_data = 1'b0;
    for (int k = 0; k < SOI; k++) begin
      @(negedge clk);
      observe("R4", 1'b1, 1'b1);
      chk("R5", tx_active, 1'b1);
    end
    @(negedge clk);
    observe("R4", 1'b0, 1'b0);
    chk("R5", tx_active, 1'b0);
    loopback = 1'b0;
    full_duplex = 1'b0;
  endtask

  task automatic t_collision();
    full_duplex = 1'b0;
    coll_in = 1'b1;
    @(negedge clk);
    chk("R8", col_out, 1'b1);
    coll_in = 1'b0;
    @(negedge clk);
    chk("R8", col_out, 1'b0);
    coll_in = 1'b1;
    full_duplex = 1'b1;
    @(negedge clk);
    chk("R7", col_out, 1'b0);
    coll_in = 1'b0;
    full_duplex = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_idle_no_enable();
    t_frame(16'hA5C3, 16, 1'b0, 1'b0);
    t_frame(16'h0001, 3, 1'b0, 1'b0);
    t_frame(16'h00FF, 8, 1'b0, 1'b0);
    t_frame(16'h0000, 5, 1'b0, 1'b0);
    t_frame(16'h3C96, 12, 1'b1, 1'b0);
    t_frame(16'h5A69, 10, 1'b1, 1'b1);
    t_frame(16'h0002, 2, 1'b0, 1'b1);
    t_collision();
    t_idle_no_enable();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule